// File: doc/BRIEF.md
# Thread Identifier CSR Unit

This unit keeps a trusted thread identifier that privileged software rewrites on every context switch and that unprivileged code can read but never alter. Unlike the general-purpose thread pointer, which any code can overwrite, this value comes from a control register. Compartment entry code can therefore rely on it to tell which thread is calling.

The stored value has two views. The capability view is `2*XLEN+1` bits wide and holds a validity tag, a metadata half and an address half. The integer view is `XLEN` bits wide and covers only the address half. The unit answers CSR accesses at two addresses:

- **Supervisor address.** Holds the register. Reads and writes are allowed from privileged modes that also hold the system-register permission.
- **User address.** Has no storage of its own. It returns the live contents of the supervisor register and never accepts a write.

Reads are combinational. A write lands on the next rising clock edge.

Top module: `tid_csr_unit`

## Requirements
- R1: A cycle with `rst` high clears the tag bit, so a capability-width read (`csr_cap_i`=1) returns bit `2*XLEN` equal to 0 until a later capability write sets it.
- R2: An access to `SUP_ADDR` with `csr_priv_i` below supervisor (encodings: 0 user, 1 supervisor, 2 hypervisor, 3 machine) or with `csr_sysperm_i` low raises `csr_illegal_o`, returns zero read data and leaves the stored value unchanged.
- R3: A legal capability-width write to `SUP_ADDR` stores `csr_wdata_i` as follows: tag from bit `2*XLEN`, metadata from bits `2*XLEN-1:XLEN`, address from bits `XLEN-1:0`. A capability-width read returns them in the same layout.
- R4: A legal integer-width write (`csr_cap_i`=0) to `SUP_ADDR` loads `csr_wdata_i[XLEN-1:0]` into the address half, clears the tag and keeps the metadata.
- R5: An integer-width read returns the address half in bits `XLEN-1:0`, with every higher bit zero.
- R6: A read of `USR_ADDR` from any privilege level, with or without the permission, returns what the same-width read of `SUP_ADDR` would return, and does not raise `csr_illegal_o`.
- R7: Any write to `USR_ADDR` raises `csr_illegal_o` at any privilege level and leaves the stored value unchanged.
- R8: A request to any other address returns zero read data, keeps `csr_illegal_o` low and changes nothing.
- R9: A write is visible through both addresses in the cycle after the clock edge that accepts it.
- R10: With `csr_req_i` low, `csr_rdata_o` is zero and `csr_illegal_o` is low whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req_i | input | 1 | Access valid this cycle |
| csr_addr_i | input | ADDR_W | CSR address |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_cap_i | input | 1 | 1 = capability-width access, 0 = integer-width |
| csr_priv_i | input | 2 | Current privilege level (0 U, 1 S, 2 H, 3 M) |
| csr_sysperm_i | input | 1 | System-register access permission held |
| csr_wdata_i | input | 2*XLEN+1 | Write data in capability layout |
| csr_rdata_o | output | 2*XLEN+1 | Read data, zero when not a legal read |
| csr_illegal_o | output | 1 | Access rejected |

## Verification
The bench builds the unit with `XLEN` = 16 and the default 12-bit addresses at 0x580 and 0xC80. A 33-bit capability then holds distinct, recognisable patterns in each of the three fields. This shows directly when a field is dropped, shifted, left in place by an integer write, or cleared when it should stay. Each privilege level is tried with the permission both set and clear, so every gating corner is covered. The narrow width also makes it easy to see zero-extension in integer reads, and to see that near-miss addresses such as 0x581 and 0xC81 are ignored.

// File: rtl/tid_pkg.sv
package tid_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef struct packed {
    logic hit_sup;
    logic hit_usr;
    logic rd_en;
    logic wr_en;
    logic fault;
  } tid_dec_t;

endpackage

// File: rtl/tid_decode.sv
module tid_decode
  import tid_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SUP_ADDR = 12'h580,
  parameter logic [ADDR_W-1:0] USR_ADDR = 12'hC80
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  priv_e             priv_i,
  input  logic              perm_i,
  output tid_dec_t          dec_o
);

  logic sup_ok;

  always_comb begin
    sup_ok        = (priv_i >= PRIV_S) && perm_i;
    dec_o.hit_sup = req_i && (addr_i == SUP_ADDR);
    dec_o.hit_usr = req_i && (addr_i == USR_ADDR);
    dec_o.fault   = (dec_o.hit_sup && !sup_ok) || (dec_o.hit_usr && we_i);
    dec_o.rd_en   = (dec_o.hit_sup && sup_ok) || (dec_o.hit_usr && !we_i);
    dec_o.wr_en   = dec_o.hit_sup && sup_ok && we_i;
  end

  always_comb begin
    if (dec_o.wr_en) begin
      assert (!dec_o.fault) else $error("p_write_not_faulted_r2");
    end
  end

endmodule

// File: rtl/tid_store.sv
module tid_store #(
  parameter int XLEN = 32,
  localparam int CLEN = 2 * XLEN + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            wr_cap_i,
  input  logic [CLEN-1:0] wdata_i,
  output logic            tag_q,
  output logic [XLEN-1:0] meta_q,
  output logic [XLEN-1:0] addr_q
);

  localparam int TAG_BIT = 2 * XLEN;

  // Only the tag carries a reset; the data halves are plain enabled flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= 1'b0;
    end else if (wr_en_i) begin
      tag_q <= wr_cap_i ? wdata_i[TAG_BIT] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      addr_q <= wdata_i[XLEN-1:0];
      if (wr_cap_i) begin
        meta_q <= wdata_i[TAG_BIT-1:XLEN];
      end
    end
  end

  property p_tag_cleared_r1;
    @(posedge clk) rst |=> (tag_q == 1'b0);
  endproperty
  assert property (p_tag_cleared_r1);

  property p_cap_write_r3;
    @(posedge clk) disable iff (rst)
      (wr_en_i && wr_cap_i) |=>
        (tag_q == $past(wdata_i[TAG_BIT])) &&
        (meta_q == $past(wdata_i[TAG_BIT-1:XLEN])) &&
        (addr_q == $past(wdata_i[XLEN-1:0]));
  endproperty
  assert property (p_cap_write_r3);

  property p_int_write_clears_tag_r4;
    @(posedge clk) disable iff (rst)
      (wr_en_i && !wr_cap_i) |=>
        (!tag_q && (addr_q == $past(wdata_i[XLEN-1:0])));
  endproperty
  assert property (p_int_write_clears_tag_r4);

endmodule

// File: rtl/tid_readmux.sv
module tid_readmux #(
  parameter int XLEN = 32,
  localparam int CLEN = 2 * XLEN + 1
) (
  input  logic            rd_en_i,
  input  logic            cap_i,
  input  logic            tag_i,
  input  logic [XLEN-1:0] meta_i,
  input  logic [XLEN-1:0] addr_i,
  output logic [CLEN-1:0] rdata_o
);

  always_comb begin
    if (!rd_en_i) begin
      rdata_o = '0;
    end else if (cap_i) begin
      rdata_o = {tag_i, meta_i, addr_i};
    end else begin
      rdata_o = {{(XLEN + 1){1'b0}}, addr_i};
    end
  end

endmodule

// File: rtl/tid_csr_unit.sv
module tid_csr_unit
  import tid_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SUP_ADDR = 12'h580,
  parameter logic [ADDR_W-1:0] USR_ADDR = 12'hC80,
  localparam int CLEN = 2 * XLEN + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_req_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic              csr_cap_i,
  input  logic [1:0]        csr_priv_i,
  input  logic              csr_sysperm_i,
  input  logic [CLEN-1:0]   csr_wdata_i,
  output logic [CLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o
);

  tid_dec_t        dec;
  logic            tag_q;
  logic [XLEN-1:0] meta_q;
  logic [XLEN-1:0] addr_q;

  tid_decode #(
    .ADDR_W  (ADDR_W),
    .SUP_ADDR(SUP_ADDR),
    .USR_ADDR(USR_ADDR)
  ) u_decode (
    .req_i (csr_req_i),
    .addr_i(csr_addr_i),
    .we_i  (csr_we_i),
    .priv_i(priv_e'(csr_priv_i)),
    .perm_i(csr_sysperm_i),
    .dec_o (dec)
  );

  tid_store #(.XLEN(XLEN)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (dec.wr_en),
    .wr_cap_i(csr_cap_i),
    .wdata_i (csr_wdata_i),
    .tag_q   (tag_q),
    .meta_q  (meta_q),
    .addr_q  (addr_q)
  );

  tid_readmux #(.XLEN(XLEN)) u_rmux (
    .rd_en_i(dec.rd_en),
    .cap_i  (csr_cap_i),
    .tag_i  (tag_q),
    .meta_i (meta_q),
    .addr_i (addr_q),
    .rdata_o(csr_rdata_o)
  );

  assign csr_illegal_o = dec.fault;

  property p_sup_gated_r2;
    @(posedge clk) disable iff (rst)
      (csr_req_i && (csr_addr_i == SUP_ADDR) &&
       ((csr_priv_i == 2'd0) || !csr_sysperm_i))
      |-> (csr_illegal_o && (csr_rdata_o == '0));
  endproperty
  assert property (p_sup_gated_r2);

  property p_illegal_keeps_tag_r2;
    @(posedge clk) disable iff (rst)
      (csr_illegal_o && csr_we_i) |=> $stable(tag_q);
  endproperty
  assert property (p_illegal_keeps_tag_r2);

  property p_mirror_cap_r6;
    @(posedge clk) disable iff (rst)
      (csr_req_i && !csr_we_i && csr_cap_i && (csr_addr_i == USR_ADDR))
      |-> (!csr_illegal_o && (csr_rdata_o == {tag_q, meta_q, addr_q}));
  endproperty
  assert property (p_mirror_cap_r6);

  property p_user_write_illegal_r7;
    @(posedge clk) disable iff (rst)
      (csr_req_i && csr_we_i && (csr_addr_i == USR_ADDR)) |-> csr_illegal_o;
  endproperty
  assert property (p_user_write_illegal_r7);

  property p_other_quiet_r8;
    @(posedge clk) disable iff (rst)
      (csr_req_i && (csr_addr_i != SUP_ADDR) && (csr_addr_i != USR_ADDR))
      |-> (!csr_illegal_o && (csr_rdata_o == '0));
  endproperty
  assert property (p_other_quiet_r8);

  property p_idle_quiet_r10;
    @(posedge clk) disable iff (rst)
      !csr_req_i |-> (!csr_illegal_o && (csr_rdata_o == '0));
  endproperty
  assert property (p_idle_quiet_r10);

endmodule

// File: tb/tid_csr_unit_tb.sv
module tid_csr_unit_tb;

  localparam int XLEN = 16;
  localparam int CLEN = 2 * XLEN + 1;
  localparam logic [11:0] SUP = 12'h580;
  localparam logic [11:0] USR = 12'hC80;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req = 1'b0;
  logic [11:0]     addr = '0;
  logic            we = 1'b0;
  logic            cap = 1'b0;
  logic [1:0]      priv = 2'd3;
  logic            perm = 1'b0;
  logic [CLEN-1:0] wdata = '0;
  logic [CLEN-1:0] rdata;
  logic            illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tid_csr_unit #(.XLEN(XLEN)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .csr_req_i    (req),
    .csr_addr_i   (addr),
    .csr_we_i     (we),
    .csr_cap_i    (cap),
    .csr_priv_i   (priv),
    .csr_sysperm_i(perm),
    .csr_wdata_i  (wdata),
    .csr_rdata_o  (rdata),
    .csr_illegal_o(illegal)
  );

  task automatic chk(input string rq, input logic [CLEN-1:0] act,
                     input logic [CLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic [11:0] a, input bit w, input bit c,
                     input logic [1:0] p, input bit pm,
                     input logic [CLEN-1:0] wd,
                     output logic [CLEN-1:0] rd, output logic ill);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; cap = c; priv = p; perm = pm; wdata = wd;
    #1;
    rd  = rdata;
    ill = illegal;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [CLEN-1:0] mk(input bit t, input logic [15:0] m,
                                         input logic [15:0] ad);
    return {t, m, ad};
  endfunction

  task automatic t_reset;
    logic [CLEN-1:0] rd;
    logic ill;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    acc(SUP, 0, 1, 2'd3, 1, '0, rd, ill);
    chk("R1 tag after reset", {32'd0, rd[CLEN-1]}, '0);
    acc(USR, 0, 1, 2'd0, 0, '0, rd, ill);
    chk("R1 user tag after reset", {32'd0, rd[CLEN-1]}, '0);
  endtask

  task automatic t_cap_rw;
    logic [CLEN-1:0] rd;
    logic ill;
    acc(SUP, 1, 1, 2'd1, 1, mk(1, 16'hA5C3, 16'h1234), rd, ill);
    chk("R3 cap write legal", {32'd0, ill}, '0);
    acc(SUP, 0, 1, 2'd1, 1, '0, rd, ill);
    chk("R3 R9 cap read back", rd, mk(1, 16'hA5C3, 16'h1234));
    acc(USR, 0, 1, 2'd0, 0, '0, rd, ill);
    chk("R6 R9 user cap mirror", rd, mk(1, 16'hA5C3, 16'h1234));
    chk("R6 user read legal", {32'd0, ill}, '0);
    acc(SUP, 1, 1, 2'd3, 1, mk(0, 16'hFFFF, 16'h0001), rd, ill);
    acc(SUP, 0, 1, 2'd3, 1, '0, rd, ill);
    chk("R3 cap overwrite", rd, mk(0, 16'hFFFF, 16'h0001));
  endtask

  task automatic t_int;
    logic [CLEN-1:0] rd;
    logic ill;
    acc(SUP, 1, 1, 2'd3, 1, mk(1, 16'hBEEF, 16'hCAFE), rd, ill);
    acc(SUP, 1, 0, 2'd1, 1, mk(1, 16'h7777, 16'h0042), rd, ill);
    acc(SUP, 0, 1, 2'd1, 1, '0, rd, ill);
    chk("R4 int write keeps meta clears tag", rd, mk(0, 16'hBEEF, 16'h0042));
    acc(SUP, 0, 0, 2'd1, 1, '0, rd, ill);
    chk("R5 int read zero-extended", rd, {17'd0, 16'h0042});
    acc(USR, 0, 0, 2'd2, 1, '0, rd, ill);
    chk("R6 user int mirror", rd, {17'd0, 16'h0042});
  endtask

  task automatic t_priv;
    logic [CLEN-1:0] rd;
    logic ill;
    acc(SUP, 1, 1, 2'd3, 1, mk(1, 16'h1111, 16'h2222), rd, ill);
    acc(SUP, 1, 1, 2'd0, 1, mk(0, 16'h9999, 16'h8888), rd, ill);
    chk("R2 user-mode write illegal", {32'd0, ill}, 33'd1);
    chk("R2 user-mode rdata zero", rd, '0);
    acc(SUP, 0, 1, 2'd0, 1, '0, rd, ill);
    chk("R2 user-mode read zero", {rd[CLEN-2:0], ill}, 33'd1);
    acc(SUP, 1, 0, 2'd1, 0, mk(0, 16'h0, 16'h5555), rd, ill);
    chk("R2 no permission illegal", {32'd0, ill}, 33'd1);
    acc(SUP, 1, 1, 2'd3, 0, mk(0, 16'h0, 16'h5555), rd, ill);
    chk("R2 machine without permission illegal", {32'd0, ill}, 33'd1);
    acc(SUP, 0, 1, 2'd3, 1, '0, rd, ill);
    chk("R2 state unchanged", rd, mk(1, 16'h1111, 16'h2222));
  endtask

  task automatic t_user_write;
    logic [CLEN-1:0] rd;
    logic ill;
    acc(USR, 1, 1, 2'd3, 1, mk(0, 16'hDEAD, 16'hF00D), rd, ill);
    chk("R7 user write illegal at M", {32'd0, ill}, 33'd1);
    acc(USR, 1, 0, 2'd0, 0, mk(0, 16'h0, 16'hF00D), rd, ill);
    chk("R7 user write illegal at U", {32'd0, ill}, 33'd1);
    acc(USR, 0, 1, 2'd0, 0, '0, rd, ill);
    chk("R7 state unchanged", rd, mk(1, 16'h1111, 16'h2222));
  endtask

  task automatic t_other;
    logic [CLEN-1:0] rd;
    logic ill;
    acc(12'h581, 1, 1, 2'd3, 1, mk(0, 16'h0, 16'h0), rd, ill);
    chk("R8 near address quiet", {rd[CLEN-2:0], ill}, '0);
    acc(12'hC81, 0, 1, 2'd3, 1, '0, rd, ill);
    chk("R8 near user address quiet", {rd[CLEN-2:0], ill}, '0);
    acc(12'h000, 1, 0, 2'd0, 0, '0, rd, ill);
    chk("R8 zero address quiet", {rd[CLEN-2:0], ill}, '0);
    acc(SUP, 0, 1, 2'd3, 1, '0, rd, ill);
    chk("R8 state unchanged", rd, mk(1, 16'h1111, 16'h2222));
  endtask

  task automatic t_idle;
    @(negedge clk);
    req = 1'b0; addr = USR; we = 1'b1; cap = 1'b1; priv = 2'd3; perm = 1'b1;
    wdata = mk(0, 16'h0, 16'h0);
    #1;
    chk("R10 idle rdata zero", rdata, '0);
    chk("R10 idle no illegal", {32'd0, illegal}, '0);
    addr = SUP; we = 1'b0;
    #1;
    chk("R10 idle read zero", {rdata[CLEN-2:0], illegal}, '0);
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  initial begin
    t_reset();
    t_cap_rw();
    t_int();
    t_priv();
    t_user_write();
    t_other();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule